// File: doc/BRIEF.md
# Single-Line Instruction Fetch Buffer

This block sits between a processor core that executes code straight out of a shared, word-addressed memory and the arbiter port of that memory. It keeps one aligned line of eight 32-bit instruction words together with the line's tag. While the program counter stays inside that line, every instruction is delivered from the buffer in the same cycle it is asked for. Loops and short backward branches that stay in the line therefore run without touching shared memory. When the program counter leaves the line, the block fetches the line that holds the new address. This happens on a jump, a call or entry into memory-execution mode, which the core signals with a redirect pulse, and also when straight-line code runs past the last word. The core is held in a stall until all eight words have arrived.

The same eight words are also mapped into the core's register address space as a window of eight consecutive register addresses starting at 0x1E0. Code can therefore read constants that were placed next to the instructions. A line fill takes precedence over the core's own data accesses to shared memory, which are held off while a fill is pending or in progress. Data reads and writes never alter the buffered line.

Top module: `iline_buf`

## Requirements
- R1: After reset the line is invalid: `mem_req` is low, `win_hit` is low for every window address, and the first fetch always misses (`stall`=1, `instr_valid`=0).
- R2: A fetch whose word address `fetch_pc` lies outside the valid line raises `mem_req` in the next cycle, with `mem_line_addr` equal to `fetch_pc` shifted right by 3 (32-byte lines of eight words).
- R3: `mem_req` stays high until `mem_gnt` is seen. After the grant, the words are taken in line order 0 to 7, one per `mem_rvalid` strobe. The line becomes valid in the cycle after the eighth word, and the held fetch then completes with the word at offset `fetch_pc[2:0]`.
- R4: A fetch that hits the valid line returns that word on `instr` with `instr_valid`=1, `stall`=0 and no `mem_req`, all in the same cycle.
- R5: A branch back or forward to another word of the current line, made without a redirect, hits without a refetch.
- R6: A redirect always misses and refetches the target line, even when the target is in the current line.
- R7: When sequential execution moves from word 7 of a line to word 0 of the next line, a fill of the line with tag+1 starts automatically.
- R8: While a fill is pending or in progress, a core data request is held off (`dat_hold`=1). When no fill is active, `dat_hold` is 0.
- R9: A register read at 0x1E0+k (k=0..7) returns line word k and raises `win_hit` when the line is valid. Any other register address gives `win_hit`=0 and `win_rdata`=0.
- R10: Core data requests made while no fill is active leave the buffered words, as seen through the window, unchanged.
- R11: With `fetch_req` low, `stall` and `instr_valid` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Core requests the instruction at `fetch_pc` |
| fetch_pc | input | 18 | Instruction word address |
| redirect | input | 1 | Jump, call or mode entry; forces a refetch |
| instr_valid | output | 1 | `instr` holds the requested word this cycle |
| instr | output | 32 | Instruction word |
| stall | output | 1 | Core must hold the fetch |
| win_addr | input | 9 | Register-file read address |
| win_hit | output | 1 | Address falls in the line window and the line is valid |
| win_rdata | output | 32 | Line word for a window address, else zero |
| dat_req | input | 1 | Core wants a data access to shared memory |
| dat_hold | output | 1 | Data access must wait for the fill |
| mem_req | output | 1 | Line fill request to the arbiter |
| mem_line_addr | output | 15 | Tag of the line being filled |
| mem_gnt | input | 1 | Arbiter grant |
| mem_rvalid | input | 1 | Fill word strobe |
| mem_rdata | input | 32 | Fill word |

## Verification
On every cycle, the assertions check that a fill request is held until it is granted, and that the line turns valid only on a fill strobe. They also check that a delivered instruction never comes together with a request or a redirect, that data requests are held whenever a fill is being requested, and that the buffered words stay untouched when no fill is active. Whether the right words land at the right offsets, and which fetches hit or miss, can only be shown by the bench's scenarios. These include in-line loops, crossings from word 7 into the next line, redirects into the current line, and window reads at both edges of the window, all compared against a reference model of the tag and the memory contents.

// File: rtl/iline_pkg.sv
package iline_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_FILL = 2'd2
  } fill_state_e;
endpackage

// File: rtl/ilb_rst_sync.sv
module ilb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_q_n <= stage_q;
    end
  end
endmodule

// File: rtl/ilb_fill_ctrl.sv
module ilb_fill_ctrl
  import iline_pkg::*;
#(
  parameter int TAG_W = 15,
  parameter int WORDS = 8,
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_req,
  input  logic             redirect,
  input  logic [TAG_W-1:0] pc_tag,
  input  logic             mem_gnt,
  input  logic             mem_rvalid,
  output logic             mem_req,
  output logic [TAG_W-1:0] req_tag,
  output logic [TAG_W-1:0] line_tag,
  output logic             line_valid,
  output logic             busy,
  output logic             start,
  output logic             wr_en,
  output logic [OFF_W-1:0] wr_idx
);
  localparam logic [OFF_W-1:0] LAST_IDX = OFF_W'(WORDS - 1);

  fill_state_e      st_q, st_d;
  logic [OFF_W-1:0] cnt_q, cnt_d;
  logic [TAG_W-1:0] pend_q, pend_d;
  logic [TAG_W-1:0] ltag_q, ltag_d;
  logic             lv_q, lv_d;
  logic             tag_match;

  assign tag_match = lv_q && (ltag_q == pc_tag);
  assign start     = (st_q == FS_IDLE) && (redirect || (fetch_req && !tag_match));

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    pend_d = pend_q;
    ltag_d = ltag_q;
    lv_d   = lv_q;
    case (st_q)
      FS_IDLE: begin
        if (start) begin
          st_d   = FS_REQ;
          pend_d = pc_tag;
          lv_d   = 1'b0;
        end
      end
      FS_REQ: begin
        if (mem_gnt) begin
          st_d  = FS_FILL;
          cnt_d = '0;
        end
      end
      FS_FILL: begin
        if (mem_rvalid) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST_IDX) begin
            st_d   = FS_IDLE;
            lv_d   = 1'b1;
            ltag_d = pend_q;
          end
        end
      end
      default: st_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FS_IDLE;
      cnt_q  <= '0;
      pend_q <= '0;
      ltag_q <= '0;
      lv_q   <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      lv_q  <= lv_d;
      if (start) pend_q <= pend_d;
      if (st_q == FS_FILL) ltag_q <= ltag_d;
    end
  end

  assign mem_req    = (st_q == FS_REQ);
  assign req_tag    = pend_q;
  assign line_tag   = ltag_q;
  assign line_valid = lv_q;
  assign busy       = (st_q != FS_IDLE);
  assign wr_en      = (st_q == FS_FILL) && mem_rvalid;
  assign wr_idx     = cnt_q;

  // R3: an ungranted request is kept up
  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> mem_req);

  // R3: the line turns valid only right after a fill strobe
  assert_valid_on_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_valid) |-> $past(mem_rvalid));
endmodule

// File: rtl/ilb_line_store.sv
module ilb_line_store #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 8,
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [OFF_W-1:0]            wr_idx,
  input  logic [DATA_W-1:0]           wr_data,
  output logic [WORDS-1:0][DATA_W-1:0] words
);
  for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
    logic ce;
    assign ce = wr_en && (wr_idx == OFF_W'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        words[gi] <= '0;
      end else if (ce) begin
        words[gi] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/ilb_window.sv
module ilb_window #(
  parameter int               REG_AW   = 9,
  parameter int               WORDS    = 8,
  parameter logic [REG_AW-1:0] WIN_BASE = 9'h1E0,
  localparam int              OFF_W    = $clog2(WORDS)
) (
  input  logic [REG_AW-1:0] reg_addr,
  output logic              in_win,
  output logic [OFF_W-1:0]  win_idx
);
  assign in_win  = (reg_addr[REG_AW-1:OFF_W] == WIN_BASE[REG_AW-1:OFF_W]);
  assign win_idx = reg_addr[OFF_W-1:0];
endmodule

// File: rtl/iline_buf.sv
module iline_buf #(
  parameter int               PC_W     = 18,
  parameter int               DATA_W   = 32,
  parameter int               WORDS    = 8,
  parameter int               REG_AW   = 9,
  parameter logic [REG_AW-1:0] WIN_BASE = 9'h1E0,
  localparam int              OFF_W    = $clog2(WORDS),
  localparam int              TAG_W    = PC_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_req,
  input  logic [PC_W-1:0]   fetch_pc,
  input  logic              redirect,
  output logic              instr_valid,
  output logic [DATA_W-1:0] instr,
  output logic              stall,
  input  logic [REG_AW-1:0] win_addr,
  output logic              win_hit,
  output logic [DATA_W-1:0] win_rdata,
  input  logic              dat_req,
  output logic              dat_hold,
  output logic              mem_req,
  output logic [TAG_W-1:0]  mem_line_addr,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic                         rst_q_n;
  logic [TAG_W-1:0]             pc_tag;
  logic [OFF_W-1:0]             pc_off;
  logic [TAG_W-1:0]             line_tag;
  logic                         line_valid;
  logic                         busy;
  logic                         start;
  logic                         wr_en;
  logic [OFF_W-1:0]             wr_idx;
  logic [WORDS-1:0][DATA_W-1:0] words;
  logic                         in_win;
  logic [OFF_W-1:0]             win_idx;
  logic                         hit;

  assign pc_tag = fetch_pc[PC_W-1:OFF_W];
  assign pc_off = fetch_pc[OFF_W-1:0];

  ilb_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  ilb_fill_ctrl #(.TAG_W(TAG_W), .WORDS(WORDS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .fetch_req  (fetch_req),
    .redirect   (redirect),
    .pc_tag     (pc_tag),
    .mem_gnt    (mem_gnt),
    .mem_rvalid (mem_rvalid),
    .mem_req    (mem_req),
    .req_tag    (mem_line_addr),
    .line_tag   (line_tag),
    .line_valid (line_valid),
    .busy       (busy),
    .start      (start),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx)
  );

  ilb_line_store #(.DATA_W(DATA_W), .WORDS(WORDS)) u_store (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (mem_rdata),
    .words   (words)
  );

  ilb_window #(.REG_AW(REG_AW), .WORDS(WORDS), .WIN_BASE(WIN_BASE)) u_win (
    .reg_addr (win_addr),
    .in_win   (in_win),
    .win_idx  (win_idx)
  );

  assign hit         = fetch_req && !redirect && !busy && line_valid && (line_tag == pc_tag);
  assign instr_valid = hit;
  assign instr       = words[pc_off];
  assign stall       = fetch_req && !hit;
  assign win_hit     = in_win && line_valid;
  assign win_rdata   = in_win ? words[win_idx] : '0;
  assign dat_hold    = dat_req && (busy || start);

  // R4: a delivered instruction never coincides with a fill request
  assert_hit_no_req_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    instr_valid |-> !mem_req);

  // R6: a redirect is never served from the old line
  assert_redirect_refetch_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    redirect |-> !instr_valid);

  // R8: data accesses wait while the arbiter is being asked for a line
  assert_fill_priority_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (dat_req && mem_req) |-> dat_hold);

  // R10: outside a fill the stored words do not move
  assert_line_stable_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!busy && !start) |=> $stable(words));
endmodule

// File: tb/iline_buf_test.sv
module iline_buf_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_req, redirect, dat_req, mem_gnt, mem_rvalid;
  logic [17:0] fetch_pc;
  logic [8:0]  win_addr;
  logic [31:0] mem_rdata;
  logic        instr_valid, stall, win_hit, dat_hold, mem_req;
  logic [31:0] instr, win_rdata;
  logic [14:0] mem_line_addr;

  int          vectors = 0;
  int          fails = 0;
  logic        mvalid;
  logic [14:0] mtag;

  always #2.5 clk = ~clk;

  iline_buf uut (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_pc(fetch_pc),
    .redirect(redirect), .instr_valid(instr_valid), .instr(instr), .stall(stall),
    .win_addr(win_addr), .win_hit(win_hit), .win_rdata(win_rdata),
    .dat_req(dat_req), .dat_hold(dat_hold), .mem_req(mem_req),
    .mem_line_addr(mem_line_addr), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] memword(input logic [17:0] wa);
    return ({14'd0, wa} * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // R2 R3 R7 R8: answer one line fill; called at negedge+1 of the cycle after the miss
  task automatic serve(input logic [14:0] tag, input string req);
    chk({req, " mem_req raised"}, {31'd0, mem_req}, 32'd1);
    chk({req, " line address"}, {17'd0, mem_line_addr}, {17'd0, tag});
    dat_req = 1'b1;
    #0.5;
    chk("R8 data held while requesting", {31'd0, dat_hold}, 32'd1);
    for (int h = 0; h < int'($urandom % 3); h++) begin
      @(negedge clk); #1;
      chk("R3 request held without grant", {31'd0, mem_req}, 32'd1);
    end
    mem_gnt = 1'b1;
    @(negedge clk);
    mem_gnt = 1'b0;
    for (int i = 0; i < 8; i++) begin
      mem_rvalid = 1'b1;
      mem_rdata  = memword({tag, 3'(i)});
      #1;
      chk("R8 data held during fill", {31'd0, dat_hold}, 32'd1);
      @(negedge clk);
    end
    mem_rvalid = 1'b0;
    dat_req    = 1'b0;
    mvalid     = 1'b1;
    mtag       = tag;
  endtask

  task automatic fetch(input logic [17:0] pc, input logic redir, input string req);
    logic exp_hit;
    @(negedge clk);
    fetch_req = 1'b1;
    fetch_pc  = pc;
    redirect  = redir;
    #1;
    exp_hit = mvalid && (mtag == pc[17:3]) && !redir;
    if (exp_hit) begin
      chk({req, " hit valid"}, {31'd0, instr_valid}, 32'd1);
      chk({req, " hit word"}, instr, memword(pc));
      chk({req, " hit no stall"}, {30'd0, stall, mem_req}, 32'd0);
    end else begin
      chk({req, " miss stalls"}, {30'd0, stall, instr_valid}, 32'd2);
      mvalid = 1'b0;
      @(negedge clk);
      redirect = 1'b0;
      #1;
      serve(pc[17:3], req);
      #1;
      chk({req, " R3 word after fill"}, instr, memword(pc));
      chk({req, " R3 valid after fill"}, {30'd0, instr_valid, stall}, 32'd2);
    end
  endtask

  // R9: sweep around the window and a random address
  task automatic window_check;
    for (int k = 0; k < 17; k++) begin
      logic [8:0] a;
      logic       inw;
      a   = (k == 16) ? 9'($urandom % 480) : 9'h1D8 + 9'(k);
      inw = (a[8:3] == 6'h3C);
      win_addr = a;
      #0.5;
      chk("R9 window hit", {31'd0, win_hit}, {31'd0, inw && mvalid});
      chk("R9 window data", win_rdata, inw ? memword({mtag, a[2:0]}) : 32'd0);
    end
  endtask

  initial begin
    #150000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; fetch_req = 0; redirect = 0; dat_req = 0; mem_gnt = 0;
    mem_rvalid = 0; fetch_pc = '0; win_addr = 9'h1E0; mem_rdata = '0;
    mvalid = 1'b0; mtag = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R1 reset mem_req", {31'd0, mem_req}, 32'd0);
    chk("R1 reset window", {31'd0, win_hit}, 32'd0);
    chk("R11 idle no stall", {30'd0, stall, instr_valid}, 32'd0);

    fetch(18'h40, 1'b0, "R1 first fetch");
    fetch(18'h47, 1'b0, "R4 same line");
    fetch(18'h41, 1'b0, "R5 loop back");
    fetch(18'h45, 1'b0, "R5 forward in line");
    window_check();

    // R10: data traffic with the line idle
    @(negedge clk);
    fetch_req = 1'b0;
    dat_req   = 1'b1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); #1;
      chk("R10 no hold when idle", {31'd0, dat_hold}, 32'd0);
      chk("R11 no stall", {31'd0, stall}, 32'd0);
    end
    dat_req = 1'b0;
    window_check();

    fetch(18'h47, 1'b0, "R4 last word");
    fetch(18'h48, 1'b0, "R7 cross to next line");
    fetch(18'h4A, 1'b1, "R6 redirect same line");
    fetch(18'h4B, 1'b0, "R4 after redirect");
    window_check();

    for (int it = 0; it < 300; it++) begin
      logic [17:0] pc;
      int          mode;
      mode = int'($urandom % 4);
      case (mode)
        0: pc = {mtag, 3'($urandom % 8)};
        1: pc = fetch_pc + 18'd1;
        2: pc = 18'($urandom);
        default: pc = {mtag, 3'($urandom % 8)};
      endcase
      if (mode == 1)
        fetch(pc, 1'b0, (pc[2:0] == 3'd0) ? "R7 sequential" : "R4 sequential");
      else if (mode == 0)
        fetch(pc, 1'b0, "R5 in-line branch");
      else
        fetch(pc, 1'b1, "R6 redirect");
      if (it % 50 == 0) window_check();
    end

    @(negedge clk);
    fetch_req = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule